// File: doc/BRIEF.md
# Fetch-Side Branch Predictor

This block sits beside PC generation and decides, for every fetch address handed to it, whether the next fetch should jump and where to. The address is first used to read a small direct-mapped target buffer; the stored tag and target come out one cycle later. In that second cycle the accepted address is XORed with a global history register. The result selects a 2-bit saturating counter, and the counter together with the buffer hit gives the taken decision and the predicted target.

Every prediction is recorded in an in-order queue. The record holds the fetch address, the counter index, the history before the prediction, the buffer hit and target, and the decision. The execute stage later returns the real outcome of the oldest record. That outcome trains the counter and, for taken branches with a missing or stale target, rewrites the buffer entry. When the prediction turns out wrong, the block flags a mispredict, empties the queue, drops the prediction in flight and repairs the history.

Back-pressure: a fetch address is taken on a cycle where `fetch_valid` and `fetch_ready` are both high. `fetch_ready` depends only on registered state. The prediction port has no ready: PC generation must use `pred_valid` in the cycle it is high. A resolution is consumed on a cycle where `resolve_valid` and `resolve_ready` are both high. `resolve_ready` is high whenever at least one prediction waits.

Top module: `fetch_predictor`

## Requirements
- R1: After reset all buffer entries are invalid, every counter holds 01 (weakly not-taken), the history is zero and the queue is empty, so `fetch_ready`=1, `resolve_ready`=0 and `pred_valid`=0.
- R2: A fetch address accepted in cycle k produces `pred_valid`=1 in cycle k+1, unless `mispredict` is high in cycle k or k+1, which drops it.
- R3: The buffer is indexed by PC[BTB_IDX_W:1] and tagged with PC[PC_W-1:BTB_IDX_W+1]. A hit needs a valid entry with an equal tag. The read sees the contents from before any write made in the acceptance cycle.
- R4: The counter index is PC[PHT_IDX_W:1] of the address accepted in the previous cycle XOR the history. `pred_taken` = hit AND counter bit 1. `pred_target` is the stored target when taken, else zero.
- R5: Each emitted prediction enters the queue. `resolve_ready`=1 exactly when the queue holds a record, and a resolution handshake retires the oldest record.
- R6: A retired record moves its counter one step toward the outcome (taken up, not-taken down), saturating at 00 and 11. A prediction in the same cycle reads the old value.
- R7: Each emitted prediction shifts its `pred_taken` into history bit 0, dropping the top bit.
- R8: `mispredict`=1 in a resolution cycle when the recorded decision differs from `resolve_taken`, or when both are taken and the recorded target differs from `resolve_target`.
- R9: On a mispredict the queue empties, the prediction of that cycle is dropped (`pred_valid`=0), and the history becomes the recorded history shifted left with `resolve_taken` as bit 0.
- R10: A retired taken outcome whose record had no hit, or a different target, writes the entry at that address with its tag and `resolve_target`.
- R11: `fetch_ready`=0 while queued records plus the prediction in flight equal Q_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch address offered |
| fetch_ready | output | 1 | Fetch address can be accepted |
| fetch_pc | input | PC_W | Fetch address |
| pred_valid | output | 1 | Prediction for the address accepted last cycle |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | PC_W | Predicted target, zero when not taken |
| resolve_valid | input | 1 | Outcome for the oldest prediction offered |
| resolve_ready | output | 1 | A prediction is waiting for its outcome |
| resolve_taken | input | 1 | Actual direction |
| resolve_target | input | PC_W | Actual target when taken |
| mispredict | output | 1 | The resolution in this cycle disagrees with its prediction |

## Verification
The delicate overlap is a prediction leaving stage two in the same cycle that a resolution retires the queue head. A counter update, a history shift or repair, a buffer write and a queue push and pop then all act together. The bench offers fetch addresses and resolutions together in most cycles, with a few aliasing addresses and two targets, so that retirements, mispredicts, same-index buffer writes and fresh lookups collide often. A cycle-level reference model built from the requirements predicts every output in every cycle, including the dropped prediction and the repaired history that show up in later decisions.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef logic [1:0] sat2_t;

  localparam sat2_t SAT2_INIT = 2'b01;

  function automatic sat2_t sat2_step(input sat2_t c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/fp_btb.sv
module fp_btb #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_target,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target
);
  localparam int TAG_W   = PC_W - IDX_W - 1;
  localparam int ENTRIES = 1 << IDX_W;

  logic             vld_r [ENTRIES];
  logic [TAG_W-1:0] tag_r [ENTRIES];
  logic [PC_W-1:0]  tgt_r [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  logic             q_vld;
  logic [TAG_W-1:0] q_tag;
  logic [TAG_W-1:0] q_req_tag;
  logic [PC_W-1:0]  q_tgt;

  logic unused_lsb;
  assign unused_lsb = ^{rd_pc[0], wr_pc[0]};

  assign rd_idx = rd_pc[IDX_W:1];
  assign rd_tag = rd_pc[PC_W-1:IDX_W+1];
  assign wr_idx = wr_pc[IDX_W:1];
  assign wr_tag = wr_pc[PC_W-1:IDX_W+1];

  // valid bits carry reset, payload arrays do not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) vld_r[i] <= 1'b0;
    end else if (wr_en) begin
      vld_r[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_r[wr_idx] <= wr_tag;
      tgt_r[wr_idx] <= wr_target;
    end
  end

  // registered read: stage two sees the array as it was before this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld     <= 1'b0;
      q_tag     <= '0;
      q_req_tag <= '0;
      q_tgt     <= '0;
    end else if (rd_en) begin
      q_vld     <= vld_r[rd_idx];
      q_tag     <= tag_r[rd_idx];
      q_req_tag <= rd_tag;
      q_tgt     <= tgt_r[rd_idx];
    end
  end

  assign rd_hit    = q_vld && (q_tag == q_req_tag);
  assign rd_target = q_tgt;
endmodule

// File: rtl/fp_pht.sv
module fp_pht #(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output fp_pkg::sat2_t     rd_ctr,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_taken
);
  localparam int ENTRIES = 1 << IDX_W;

  fp_pkg::sat2_t ctr_r [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_r[i] <= fp_pkg::SAT2_INIT;
    end else if (upd_en) begin
      ctr_r[upd_idx] <= fp_pkg::sat2_step(ctr_r[upd_idx], upd_taken);
    end
  end

  assign rd_ctr = ctr_r[rd_idx];
endmodule

// File: rtl/fp_fifo.sv
module fp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= push_data;
  end

  assign head_data = mem[rp];
endmodule

// File: rtl/fetch_predictor.sv
module fetch_predictor #(
  parameter int PC_W      = 32,
  parameter int BTB_IDX_W = 4,
  parameter int PHT_IDX_W = 6,
  parameter int Q_DEPTH   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  output logic            fetch_ready,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  input  logic            resolve_valid,
  output logic            resolve_ready,
  input  logic            resolve_taken,
  input  logic [PC_W-1:0] resolve_target,
  output logic            mispredict
);
  localparam int HIST_W = PHT_IDX_W;
  localparam int CNT_W  = $clog2(Q_DEPTH + 1);

  typedef struct packed {
    logic [PC_W-1:0]      pc;
    logic [PHT_IDX_W-1:0] pidx;
    logic [HIST_W-1:0]    hist;
    logic                 hit;
    logic [PC_W-1:0]      tgt;
    logic                 taken;
  } rec_t;

  localparam int REC_W = $bits(rec_t);

  // stage two registers
  logic            s1_valid;
  logic [PC_W-1:0] s1_pc;
  logic [HIST_W-1:0] ghr_q;

  logic            fetch_fire, resolve_fire;
  logic            btb_hit;
  logic [PC_W-1:0] btb_tgt;
  logic [PHT_IDX_W-1:0] pidx;
  fp_pkg::sat2_t   ctr;
  logic            guess_taken;

  rec_t            new_rec, head;
  logic [REC_W-1:0] head_raw;
  logic [CNT_W-1:0] q_count;

  logic            btb_wr;

  assign fetch_ready  = (32'(q_count) + 32'(s1_valid)) < Q_DEPTH;
  assign fetch_fire   = fetch_valid && fetch_ready;

  assign resolve_ready = (q_count != '0);
  assign resolve_fire  = resolve_valid && resolve_ready;
  assign head          = rec_t'(head_raw);

  assign mispredict = resolve_fire &&
                      ((head.taken != resolve_taken) ||
                       (resolve_taken && (head.tgt != resolve_target)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pc    <= '0;
    end else begin
      s1_valid <= fetch_fire && !mispredict;
      if (fetch_fire) s1_pc <= fetch_pc;
    end
  end

  fp_btb #(
    .PC_W (PC_W),
    .IDX_W(BTB_IDX_W)
  ) u_btb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (fetch_fire),
    .rd_pc    (fetch_pc),
    .rd_hit   (btb_hit),
    .rd_target(btb_tgt),
    .wr_en    (btb_wr),
    .wr_pc    (head.pc),
    .wr_target(resolve_target)
  );

  assign pidx = s1_pc[PHT_IDX_W:1] ^ ghr_q;

  fp_pht #(
    .IDX_W(PHT_IDX_W)
  ) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pidx),
    .rd_ctr   (ctr),
    .upd_en   (resolve_fire),
    .upd_idx  (head.pidx),
    .upd_taken(resolve_taken)
  );

  assign guess_taken = btb_hit && ctr[1];
  assign pred_valid  = s1_valid && !mispredict;
  assign pred_taken  = guess_taken;
  assign pred_target = guess_taken ? btb_tgt : '0;

  assign new_rec.pc    = s1_pc;
  assign new_rec.pidx  = pidx;
  assign new_rec.hist  = ghr_q;
  assign new_rec.hit   = btb_hit;
  assign new_rec.tgt   = btb_tgt;
  assign new_rec.taken = guess_taken;

  fp_fifo #(
    .W    (REC_W),
    .DEPTH(Q_DEPTH)
  ) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (mispredict),
    .push     (pred_valid),
    .push_data(new_rec),
    .pop      (resolve_fire),
    .head_data(head_raw),
    .count    (q_count)
  );

  assign btb_wr = resolve_fire && resolve_taken &&
                  (!head.hit || (head.tgt != resolve_target));

  // speculative history with repair from the retired record
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghr_q <= '0;
    end else if (mispredict) begin
      ghr_q <= {head.hist[HIST_W-2:0], resolve_taken};
    end else if (pred_valid) begin
      ghr_q <= {ghr_q[HIST_W-2:0], guess_taken};
    end
  end
endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
  parameter int PC_W    = 32,
  parameter int HIST_W  = 6,
  parameter int Q_DEPTH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         fetch_valid,
  input logic                         fetch_ready,
  input logic                         pred_valid,
  input logic                         pred_taken,
  input logic [PC_W-1:0]              pred_target,
  input logic                         resolve_valid,
  input logic                         resolve_ready,
  input logic                         mispredict,
  input logic [$clog2(Q_DEPTH+1)-1:0] fifo_cnt,
  input logic [HIST_W-1:0]            ghr
);
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_cnt) <= Q_DEPTH);

  p_pred_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && !mispredict) |=> (pred_valid || mispredict));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> (!resolve_ready && !pred_valid));

  p_misp_needs_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> (resolve_valid && resolve_ready));

  p_target_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_taken) |-> (pred_target == '0));

  p_push_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> resolve_ready);

  p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> (ghr == {$past(ghr[HIST_W-2:0]), $past(pred_taken)}));
endmodule

bind fetch_predictor fp_checker #(
  .PC_W   (PC_W),
  .HIST_W (PHT_IDX_W),
  .Q_DEPTH(Q_DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_valid  (fetch_valid),
  .fetch_ready  (fetch_ready),
  .pred_valid   (pred_valid),
  .pred_taken   (pred_taken),
  .pred_target  (pred_target),
  .resolve_valid(resolve_valid),
  .resolve_ready(resolve_ready),
  .mispredict   (mispredict),
  .fifo_cnt     (q_count),
  .ghr          (ghr_q)
);

// File: tb/fetch_predictor_tb.sv
module fetch_predictor_tb;
  localparam int PC_W = 32;
  localparam int BI   = 4;
  localparam int PI   = 6;
  localparam int QD   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            fetch_valid = 1'b0, fetch_ready;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_valid, pred_taken;
  logic [PC_W-1:0] pred_target;
  logic            resolve_valid = 1'b0, resolve_ready, resolve_taken = 1'b0;
  logic [PC_W-1:0] resolve_target = '0;
  logic            mispredict;

  fetch_predictor #(.PC_W(PC_W), .BTB_IDX_W(BI), .PHT_IDX_W(PI), .Q_DEPTH(QD)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_target(pred_target),
    .resolve_valid(resolve_valid), .resolve_ready(resolve_ready),
    .resolve_taken(resolve_taken), .resolve_target(resolve_target),
    .mispredict(mispredict)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string focus = "R3";

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, built from the requirements
  typedef struct {
    logic [PC_W-1:0] pc;
    logic [PI-1:0]   pidx;
    logic [PI-1:0]   hist;
    logic            hit;
    logic [PC_W-1:0] tgt;
    logic            taken;
  } mrec_t;

  mrec_t           mq[$];
  logic            m_bv [1<<BI];
  logic [PC_W-BI-2:0] m_btag [1<<BI];
  logic [PC_W-1:0] m_btgt [1<<BI];
  logic [1:0]      m_pht [1<<PI];
  logic [PI-1:0]   m_ghr;
  logic            m_s1v;
  logic [PC_W-1:0] m_s1pc;
  logic            m_s1hit;
  logic [PC_W-1:0] m_s1tgt;

  function automatic logic m_misp();
    if (!(resolve_valid && mq.size() > 0)) return 1'b0;
    return (mq[0].taken != resolve_taken) || (resolve_taken && mq[0].tgt != resolve_target);
  endfunction

  function automatic logic [PI-1:0] m_pidx();
    return m_s1pc[PI:1] ^ m_ghr;
  endfunction

  function automatic logic m_taken();
    return m_s1hit && m_pht[m_pidx()][1];
  endfunction

  function automatic logic m_ready();
    return (mq.size() + int'(m_s1v)) < QD;
  endfunction

  always @(posedge clk) begin
    logic misp, acc, pt, nhit;
    logic [PI-1:0] pi;
    logic [BI-1:0] bidx, widx;
    logic [PC_W-1:0] ntgt;
    mrec_t h;
    if (!rst_n) begin
      for (int i = 0; i < (1<<BI); i++) begin m_bv[i] = 1'b0; m_btag[i] = '0; m_btgt[i] = '0; end
      for (int i = 0; i < (1<<PI); i++) m_pht[i] = 2'b01;
      m_ghr = '0; m_s1v = 1'b0; m_s1pc = '0; m_s1hit = 1'b0; m_s1tgt = '0;
      mq.delete();
    end else begin
      misp = m_misp();
      acc  = fetch_valid && m_ready();
      pi   = m_pidx();
      pt   = m_taken();
      bidx = fetch_pc[BI:1];
      nhit = m_bv[bidx] && (m_btag[bidx] == fetch_pc[PC_W-1:BI+1]);
      ntgt = m_btgt[bidx];
      h = '{default: '0};
      if (resolve_valid && mq.size() > 0) begin
        h = mq.pop_front();
        if (resolve_taken) m_pht[h.pidx] = (m_pht[h.pidx] == 2'b11) ? 2'b11 : m_pht[h.pidx] + 2'd1;
        else               m_pht[h.pidx] = (m_pht[h.pidx] == 2'b00) ? 2'b00 : m_pht[h.pidx] - 2'd1;
        if (resolve_taken && (!h.hit || h.tgt != resolve_target)) begin
          widx = h.pc[BI:1];
          m_bv[widx] = 1'b1; m_btag[widx] = h.pc[PC_W-1:BI+1]; m_btgt[widx] = resolve_target;
        end
      end
      if (misp) begin
        m_ghr = {h.hist[PI-2:0], resolve_taken};
        mq.delete();
        m_s1v = 1'b0;
      end else begin
        if (m_s1v) begin
          mq.push_back('{m_s1pc, pi, m_ghr, m_s1hit, m_s1tgt, pt});
          m_ghr = {m_ghr[PI-2:0], pt};
        end
        m_s1v = acc;
      end
      if (acc) begin m_s1pc = fetch_pc; m_s1hit = nhit; m_s1tgt = ntgt; end
    end
  end

  // monitor: compares every output against the model away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11", "fetch_ready", 64'(fetch_ready), 64'(m_ready()));
      chk("R5", "resolve_ready", 64'(resolve_ready), 64'(mq.size() > 0));
      chk({"R8/", focus}, "mispredict", 64'(mispredict), 64'(m_misp()));
      chk({"R2/", focus}, "pred_valid", 64'(pred_valid), 64'(m_s1v && !m_misp()));
      if (pred_valid && m_s1v) begin
        chk({"R4/", focus}, "pred_taken", 64'(pred_taken), 64'(m_taken()));
        chk({"R3/", focus}, "pred_target", 64'(pred_target), 64'(m_taken() ? m_s1tgt : '0));
      end
    end
  end

  task automatic step(input logic lv, input logic [PC_W-1:0] pc,
                      input logic rv, input logic rt, input logic [PC_W-1:0] tg);
    fetch_valid = lv; fetch_pc = pc;
    resolve_valid = rv; resolve_taken = rt; resolve_target = tg;
    @(posedge clk); #1;
  endtask

  localparam logic [PC_W-1:0] PA = 32'h0000_0104;
  localparam logic [PC_W-1:0] TA = 32'h0000_3000;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "fetch_ready", 64'(fetch_ready), 64'd1);
    chk("R1", "resolve_ready", 64'(resolve_ready), 64'd0);
    chk("R1", "pred_valid", 64'(pred_valid), 64'd0);
    @(posedge clk); #1;

    // first sight of a taken branch: miss, then mispredict, then a buffer fill
    focus = "R10";
    step(1, PA, 0, 0, '0);
    step(0, '0, 0, 0, '0);
    step(0, '0, 1, 1, TA);
    step(1, PA, 0, 0, '0);
    step(0, '0, 1, 1, TA);

    // train one branch repeatedly to walk its counters to saturation
    focus = "R6";
    for (int i = 0; i < 10; i++) begin
      step(1, PA, 0, 0, '0);
      step(0, '0, 0, 0, '0);
      step(0, '0, 1, 1, TA);
    end
    for (int i = 0; i < 6; i++) begin
      step(1, PA, 0, 0, '0);
      step(0, '0, 0, 0, '0);
      step(0, '0, 1, 0, '0);
    end

    // fill the queue with no resolutions
    focus = "R11";
    for (int i = 0; i < 8; i++) step(1, PA + 32'(2 * i), 0, 0, '0);
    focus = "R7";
    for (int i = 0; i < 6; i++) step(0, '0, 1, 1'(m_misp() ? 0 : 0), '0);

    // concurrent lookups and resolutions with aliasing addresses
    focus = "R9";
    for (int i = 0; i < 3000; i++) begin
      logic lv, rv, rt;
      logic [PC_W-1:0] pc, tg;
      lv = ($urandom % 4) != 0;
      pc = ((($urandom % 2) != 0) ? 32'h0000_1000 : 32'h0000_2000) + 32'(($urandom % 8) * 2);
      rv = ($urandom % 2) != 0;
      rt = ($urandom % 3) != 0;
      tg = TA + 32'(($urandom % 2) * 4);
      step(lv, pc, rv, rt, tg);
    end
    step(0, '0, 0, 0, '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule